// File: doc/BRIEF.md
# Reference Input Selection Controller

This block decides which of three reference clock inputs is the active one, or whether holdover is being asked for. A three-bit mode field either forces one input directly (manual selection) or hands the choice to two external select pins (pin selection). Each pin has a type bit. A pin whose type is "output" is read as low. A single inversion bit then flips both pins before the pin code is decoded.

The block also drives the enable signal of each input buffer. An input that is currently selected has its buffer switched on even when its programmed enable bit is clear. When the holdover status falls while manual selection is in force, the block gives a one-cycle relock pulse that names the input given by the mode field. Mode codes 4 to 7 are reserved. While one of them is applied, the block keeps its last decision and flags the mode as invalid. The clock multiplexer itself, automatic switching and all PLL behaviour lie outside this block.

Top module: `refInputSelect`

## Requirements
- R1: With `modeSel` equal to 0, 1 or 2, `activeIdx` takes that value and `holdoverReq` is 0 after the next rising clock edge.
- R2: With `modeSel` equal to 3, the effective pin code {sel1, sel0} selects as follows: 00 gives `activeIdx`=0, 01 gives 1, 10 gives 2.
- R3: In pin selection, the effective code 11 sets `holdoverReq` to 1 and leaves `activeIdx` at its last selected value.
- R4: A select pin whose `pinIsInput` bit is 0 is read as logic 0, whatever level is on the pin.
- R5: When `pinInvert` is 1, both effective select bits are inverted after the forcing of R4. A pin typed as output therefore reads as 1.
- R6: `bufEn[i]` equals `inputEn[i]`, or 1 when input i is selected and `holdoverReq` is 0. It follows `inputEn` in the same cycle.
- R7: When `holdoverActive` is sampled 0 at an edge after being 1 at the edge before, and `modeSel` is 0 to 2, `relockValid` is 1 for exactly the following cycle and `relockIdx` equals that `modeSel`.
- R8: While `modeSel` is 4 to 7, `activeIdx` and `holdoverReq` keep their values and `modeInvalid` is 1 after the next edge. A valid mode clears `modeInvalid`.
- R9: A change on `selPin` passes through a two-flop synchronizer. It reaches `activeIdx` after the third rising edge that follows the change, and not before.
- R10: While `rstN` is low, `activeIdx`=0, `holdoverReq`=0, `modeInvalid`=0 and `relockValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 3 | Selection mode: 0-2 manual, 3 pin, 4-7 reserved |
| selPin | input | 2 | External select pins {sel1, sel0}, asynchronous |
| pinIsInput | input | 2 | Per-pin type bit, 1 = input |
| pinInvert | input | 1 | Inverts both select pins |
| inputEn | input | 3 | Programmed buffer enables |
| holdoverActive | input | 1 | Holdover status from the loop |
| activeIdx | output | 2 | Index of the active input |
| holdoverReq | output | 1 | Holdover requested by the pin code |
| bufEn | output | 3 | Effective buffer enables |
| relockValid | output | 1 | One-cycle pulse on holdover exit in manual selection |
| relockIdx | output | 2 | Input to relock to |
| modeInvalid | output | 1 | Reserved mode applied |

## Verification
The assertions assume that `modeSel`, `pinIsInput`, `pinInvert`, `inputEn` and `holdoverActive` are synchronous to `clk`, and that only `selPin` may change at any time. The bench therefore changes every input at the falling edge. Each table row is held for four cycles so that pin changes settle through the synchronizer before the outputs are checked. The relock assertion takes for granted that `modeSel` does not move in the cycle that holdover ends, and the relock test keeps it steady around that edge.

// File: rtl/refSelPkg.sv
package refSelPkg;
  localparam int NUM_INPUTS = 3;
  localparam int IDX_W = $clog2(NUM_INPUTS + 1);
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_PIN = 3'd3;

  typedef struct packed {
    logic             update;    // load holdover flag
    logic             idxWrite;  // load new index
    logic [IDX_W-1:0] idx;
    logic             hold;
    logic             invalid;
    logic             relock;
    logic [IDX_W-1:0] relockIdx;
  } selStrobe_t;
endpackage

// File: rtl/refSelCtrl.sv
module refSelCtrl
  import refSelPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic [1:0]        selPin,
  input  logic [1:0]        pinIsInput,
  input  logic              pinInvert,
  input  logic              holdoverActive,
  output selStrobe_t        strobe
);
  logic [1:0] syncStage [SYNC_STAGES];
  logic       holdPrev;
  logic [1:0] pinCode;
  logic       isManual;
  logic       isPin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdPrev <= 1'b0;
    end else begin
      holdPrev <= holdoverActive;
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncStage[s] <= 2'b00;
      end else if (s == 0) begin
        syncStage[s] <= selPin;
      end else begin
        syncStage[s] <= syncStage[s-1];
      end
    end
  end

  always_comb begin
    isManual = modeSel < MODE_PIN;
    isPin    = modeSel == MODE_PIN;
    pinCode  = (syncStage[SYNC_STAGES-1] & pinIsInput) ^ {2{pinInvert}};

    strobe           = '0;
    strobe.relock    = isManual && holdPrev && !holdoverActive;
    strobe.relockIdx = IDX_W'(modeSel);
    if (isManual) begin
      strobe.update   = 1'b1;
      strobe.idxWrite = 1'b1;
      strobe.idx      = IDX_W'(modeSel);
      strobe.hold     = 1'b0;
    end else if (isPin) begin
      strobe.update   = 1'b1;
      strobe.idxWrite = pinCode != 2'b11;
      strobe.idx      = IDX_W'(pinCode);
      strobe.hold     = pinCode == 2'b11;
    end else begin
      strobe.invalid  = 1'b1;
    end
  end

  // R7: a relock pulse only ever comes from manual selection
  assert_relock_manual_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.relock |-> (modeSel < MODE_PIN) && !holdoverActive);
endmodule

// File: rtl/refSelDatapath.sv
module refSelDatapath
  import refSelPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  selStrobe_t            strobe,
  input  logic [NUM_INPUTS-1:0] inputEn,
  output logic [IDX_W-1:0]      activeIdx,
  output logic                  holdoverReq,
  output logic [NUM_INPUTS-1:0] bufEn,
  output logic                  relockValid,
  output logic [IDX_W-1:0]      relockIdx,
  output logic                  modeInvalid
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeIdx   <= '0;
      holdoverReq <= 1'b0;
      modeInvalid <= 1'b0;
      relockValid <= 1'b0;
      relockIdx   <= '0;
    end else begin
      modeInvalid <= strobe.invalid;
      relockValid <= strobe.relock;
      if (strobe.relock) relockIdx <= strobe.relockIdx;
      if (strobe.update) holdoverReq <= strobe.hold;
      if (strobe.idxWrite) activeIdx <= strobe.idx;
    end
  end

  for (genvar i = 0; i < NUM_INPUTS; i++) begin : g_buf
    assign bufEn[i] = inputEn[i] | (!holdoverReq && (activeIdx == IDX_W'(i)));
  end

  // R3: entering holdover never moves the index
  assert_hold_keeps_idx_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdoverReq) |-> $stable(activeIdx));
  // R6: programmed enables always pass, at most one input is forced on
  assert_buf_override_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((bufEn & inputEn) == inputEn) && $onehot0(bufEn & ~inputEn));
  // R6: no forced enable during holdover
  assert_hold_no_force_R6: assert property (@(posedge clk) disable iff (!rstN)
    holdoverReq |-> (bufEn == inputEn));
endmodule

// File: rtl/refInputSelect.sv
module refInputSelect
  import refSelPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeSel,
  input  logic [1:0] selPin,
  input  logic [1:0] pinIsInput,
  input  logic       pinInvert,
  input  logic [2:0] inputEn,
  input  logic       holdoverActive,
  output logic [1:0] activeIdx,
  output logic       holdoverReq,
  output logic [2:0] bufEn,
  output logic       relockValid,
  output logic [1:0] relockIdx,
  output logic       modeInvalid
);
  selStrobe_t strobe;

  refSelCtrl #(.SYNC_STAGES(2)) i_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .selPin(selPin),
    .pinIsInput(pinIsInput), .pinInvert(pinInvert),
    .holdoverActive(holdoverActive), .strobe(strobe)
  );

  refSelDatapath i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inputEn(inputEn),
    .activeIdx(activeIdx), .holdoverReq(holdoverReq), .bufEn(bufEn),
    .relockValid(relockValid), .relockIdx(relockIdx), .modeInvalid(modeInvalid)
  );

  assert_manual_sel_R1: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel < 3'd3) |=> (activeIdx == $past(modeSel[1:0])) && !holdoverReq);
  assert_reserved_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    modeSel[2] |=> $stable(activeIdx) && $stable(holdoverReq) && modeInvalid);
  assert_relock_target_R7: assert property (@(posedge clk) disable iff (!rstN)
    relockValid |-> ($past(modeSel) < 3'd3) && (relockIdx == $past(modeSel[1:0])));
  assert_relock_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    relockValid |=> !relockValid);
endmodule

// File: tb/test_refInputSelect.sv
module test_refInputSelect;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] modeSel = '0;
  logic [1:0] selPin = '0;
  logic [1:0] pinIsInput = '0;
  logic       pinInvert = 1'b0;
  logic [2:0] inputEn = '0;
  logic       holdoverActive = 1'b0;
  logic [1:0] activeIdx;
  logic       holdoverReq;
  logic [2:0] bufEn;
  logic       relockValid;
  logic [1:0] relockIdx;
  logic       modeInvalid;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  refInputSelect i_refInputSelect (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .selPin(selPin),
    .pinIsInput(pinIsInput), .pinInvert(pinInvert), .inputEn(inputEn),
    .holdoverActive(holdoverActive), .activeIdx(activeIdx),
    .holdoverReq(holdoverReq), .bufEn(bufEn), .relockValid(relockValid),
    .relockIdx(relockIdx), .modeInvalid(modeInvalid)
  );

  // {mode, pins, isInput, invert, inputEn, expIdx, expHold, expBufEn}
  localparam int NVEC = 15;
  localparam logic [16:0] VEC [NVEC] = '{
    {3'd0, 2'b00, 2'b11, 1'b0, 3'b000, 2'd0, 1'b0, 3'b001}, // R1
    {3'd1, 2'b00, 2'b11, 1'b0, 3'b100, 2'd1, 1'b0, 3'b110}, // R1 R6
    {3'd2, 2'b00, 2'b11, 1'b0, 3'b000, 2'd2, 1'b0, 3'b100}, // R1
    {3'd3, 2'b00, 2'b11, 1'b0, 3'b000, 2'd0, 1'b0, 3'b001}, // R2
    {3'd3, 2'b01, 2'b11, 1'b0, 3'b000, 2'd1, 1'b0, 3'b010}, // R2
    {3'd3, 2'b10, 2'b11, 1'b0, 3'b000, 2'd2, 1'b0, 3'b100}, // R2
    {3'd3, 2'b11, 2'b11, 1'b0, 3'b010, 2'd2, 1'b1, 3'b010}, // R3 R6
    {3'd3, 2'b11, 2'b00, 1'b0, 3'b000, 2'd0, 1'b0, 3'b001}, // R4
    {3'd3, 2'b00, 2'b00, 1'b1, 3'b000, 2'd0, 1'b1, 3'b000}, // R5 R3
    {3'd3, 2'b01, 2'b01, 1'b1, 3'b000, 2'd2, 1'b0, 3'b100}, // R4 R5
    {3'd3, 2'b10, 2'b01, 1'b0, 3'b000, 2'd0, 1'b0, 3'b001}, // R4
    {3'd3, 2'b10, 2'b11, 1'b1, 3'b000, 2'd1, 1'b0, 3'b010}, // R5
    {3'd3, 2'b00, 2'b11, 1'b1, 3'b001, 2'd1, 1'b1, 3'b001}, // R5 R3
    {3'd1, 2'b11, 2'b11, 1'b0, 3'b000, 2'd1, 1'b0, 3'b010}, // R1 pins ignored
    {3'd2, 2'b01, 2'b11, 1'b0, 3'b011, 2'd2, 1'b0, 3'b111}  // R1 R6
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    cycles(3);
    check("R10", "activeIdx", activeIdx, 0);
    check("R10", "holdoverReq", holdoverReq, 0);
    check("R10", "modeInvalid", modeInvalid, 0);
    check("R10", "relockValid", relockValid, 0);
    rstN = 1'b1;
    cycles(1);

    for (int v = 0; v < NVEC; v++) begin
      {modeSel, selPin, pinIsInput, pinInvert, inputEn} = VEC[v][16:6];
      cycles(4);
      check("R1-R6 vec", "activeIdx", activeIdx, int'(VEC[v][5:4]));
      check("R1-R6 vec", "holdoverReq", holdoverReq, int'(VEC[v][3]));
      check("R1-R6 vec", "bufEn", bufEn, int'(VEC[v][2:0]));
      check("R8 vec", "modeInvalid", modeInvalid, 0);
    end

    // R6: bufEn follows inputEn without a clock edge
    modeSel = 3'd0; inputEn = 3'b000;
    cycles(2);
    #1 inputEn = 3'b110;
    #1 check("R6", "bufEn comb", bufEn, 3'b111);
    cycles(1);

    // R1: one-cycle latency for a manual selection
    modeSel = 3'd2;
    cycles(1);
    check("R1", "activeIdx latency", activeIdx, 2);

    // R9: pin latency through the synchronizer
    modeSel = 3'd3; pinIsInput = 2'b11; pinInvert = 1'b0; inputEn = 3'b000; selPin = 2'b00;
    cycles(4);
    selPin = 2'b01;
    cycles(2);
    check("R9", "activeIdx early", activeIdx, 0);
    cycles(1);
    check("R9", "activeIdx third edge", activeIdx, 1);

    // R8: reserved mode holds selection, sets flag
    selPin = 2'b11;
    cycles(4);
    modeSel = 3'd5; selPin = 2'b10;
    cycles(4);
    check("R8", "activeIdx held", activeIdx, 1);
    check("R8", "holdoverReq held", holdoverReq, 1);
    check("R8", "modeInvalid", modeInvalid, 1);
    modeSel = 3'd0;
    cycles(1);
    check("R8", "modeInvalid cleared", modeInvalid, 0);
    check("R8", "activeIdx after", activeIdx, 0);

    // R7: relock pulse on holdover exit in manual selection
    modeSel = 3'd2;
    holdoverActive = 1'b1;
    cycles(3);
    check("R7", "relockValid during hold", relockValid, 0);
    holdoverActive = 1'b0;
    cycles(1);
    check("R7", "relockValid pulse", relockValid, 1);
    check("R7", "relockIdx", relockIdx, 2);
    cycles(1);
    check("R7", "relockValid ends", relockValid, 0);

    // R7: no relock in pin selection
    modeSel = 3'd3;
    holdoverActive = 1'b1;
    cycles(2);
    holdoverActive = 1'b0;
    cycles(1);
    check("R7", "no relock in pin mode", relockValid, 0);
    cycles(1);

    // R10: reset mid-run returns to input 0
    modeSel = 3'd1;
    cycles(2);
    rstN = 1'b0;
    #1 check("R10", "activeIdx in reset", activeIdx, 0);
    cycles(1);
    rstN = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule